// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for each of a small group of peripheral instances, whether the instance receives supply power and whether it receives a clock. The decision combines three inputs. The first is the current device power mode (run, sleep or deep-sleep). The second is a gating-enable bit for each instance in each mode. The third is a power-control bit for each instance, held in a single software register. When the gating-enable bit for the active mode is set, the instance runs normally. When it is clear, the power-control bit chooses between cutting the instance off completely and keeping it in a retention state, where it stays powered but gets no clock.

An instance that has lost power has also lost its internal state. So whenever power returns to an instance, the block drives a short reset pulse into that instance, and it keeps the clock off until that pulse ends. The power switches, the clock gate cells and the peripheral logic are outside this block. It only produces their enable and reset controls.

Top module: `pwr_clk_gate_ctrl`

## Requirements
- R1: The 2-bit mode input selects which gating-enable vector applies: 00 selects the run vector, 01 the sleep vector, 10 the deep-sleep vector, and 11 is treated as run. The vectors that are not selected have no effect on the outputs.
- R2: With the selected gating-enable bit at 1, an instance has power enable 1 and, once any repower reset has ended, clock enable 1, whatever its power-control bit holds.
- R3: With the selected gating-enable bit at 0 and the power-control bit at 0, an instance has power enable 0, clock enable 0 and peripheral reset 0.
- R4: With the selected gating-enable bit at 0 and the power-control bit at 1, an instance has power enable 1 and clock enable 0 (retention).
- R5: The power-control register sits at byte address 0x938. Bit 0 belongs to instance 0 and bit 1 to instance 1. Both bits are read/write and reset to 1. Reads of that address return bits 31:2 as 0, and reads of any other address return 0. Writes to bits 31:2, and writes to other addresses, leave the register unchanged.
- R6: Power enable and clock enable are registered. They take their new value on the first rising clock edge after a change in mode, gating-enable inputs or a register write strobe.
- R7: When an instance's power enable goes from 0 to 1, its peripheral reset is high for exactly 2 clock cycles, beginning on that same edge. Clock enable stays 0 while the reset is high. If the instance is still gated on, clock enable rises on the edge where the reset falls.
- R8: The peripheral reset pulses only on a repower event. Losing power, entering or leaving retention, and changing the clock alone never produce a pulse.
- R9: While the active-low synchronous reset is applied, the register reads 0x3, both power enables are 1, both clock enables are 0 and both peripheral resets are 1. After release, the peripheral resets stay high for 2 more clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Device power mode (00 run, 01 sleep, 10 deep-sleep, 11 run) |
| run_gate_en_i | input | 2 | Per-instance gating enable used in run mode |
| slp_gate_en_i | input | 2 | Per-instance gating enable used in sleep mode |
| dslp_gate_en_i | input | 2 | Per-instance gating enable used in deep-sleep mode |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the addressed location (combinational) |
| pwr_en_o | output | 2 | Per-instance power enable |
| clk_en_o | output | 2 | Per-instance clock enable |
| periph_rst_o | output | 2 | Per-instance peripheral reset, active high |

## Verification
Each stimulus is applied on the falling clock edge. Power enable, clock enable and peripheral reset are due on the very next rising edge. Read data depends on the register value written at that same edge. The driver pushes one expected item for each applied cycle, and the monitor takes that item off the queue a quarter period after the following rising edge. Every comparison therefore lands exactly one register stage after its stimulus. The 2-cycle reset window is then checked item by item on consecutive cycles, so a pulse that is longer, shorter, late or spurious is detected.

// File: rtl/pgc_pkg.sv
// Package: shared encodings for the power/clock gating controller.
// Assumes: a 2-bit mode code; the reserved code behaves as run mode.
package pgc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_DEEP  = 2'b10,
        MODE_RSVD  = 2'b11
    } pwr_mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/pgc_gate_sel.sv
// Module: pgc_gate_sel
// Picks the gating-enable vector that applies in the current power mode.
// Assumes: mode is stable within a cycle; the reserved code maps to run.
module pgc_gate_sel
    import pgc_pkg::*;
#(
    parameter int unsigned NUM_INST = 2
) (
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [NUM_INST-1:0] run_en_i,
    input  logic [NUM_INST-1:0] slp_en_i,
    input  logic [NUM_INST-1:0] dslp_en_i,
    output logic [NUM_INST-1:0] gate_o
);

    // Mode-driven selection of the applicable enable vector.
    always_comb begin
        unique case (pwr_mode_e'(mode_i))
            MODE_SLEEP: gate_o = slp_en_i;
            MODE_DEEP:  gate_o = dslp_en_i;
            default:    gate_o = run_en_i;
        endcase
    end

endmodule

// File: rtl/pgc_pctl_reg.sv
// Module: pgc_pctl_reg
// Holds the per-instance power-control bits and serves one word of read data.
// Assumes: a single-cycle write strobe; reads are combinational on the address.
module pgc_pctl_reg #(
    parameter int unsigned          NUM_INST   = 2,
    parameter int unsigned          ADDR_W     = 12,
    parameter int unsigned          DATA_W     = 32,
    parameter logic [ADDR_W-1:0]    REG_OFFSET = 12'h938
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_INST-1:0] pctl_q_o,
    output logic [NUM_INST-1:0] pctl_d_o
);

    logic                hit;
    logic [NUM_INST-1:0] pctl_q;

    // Address decode for this register.
    assign hit = (addr_i == REG_OFFSET);

    // Next value: only the implemented low bits take write data.
    always_comb begin
        pctl_d_o = pctl_q;
        if (wr_en_i && hit) pctl_d_o = wdata_i[NUM_INST-1:0];
    end

    // Storage of the power-control bits; all set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pctl_q <= '1;
        else        pctl_q <= pctl_d_o;
    end

    // Read mux: implemented bits at the matching address, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (hit) rdata_o[NUM_INST-1:0] = pctl_q;
    end

    assign pctl_q_o = pctl_q;

    // R5: a write anywhere else leaves the register untouched.
    assert_pctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && hit) |=> $stable(pctl_q));

    // R5: a write to this address lands its low bits.
    assert_pctl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit) |=> (pctl_q == $past(wdata_i[NUM_INST-1:0])));

endmodule

// File: rtl/pgc_inst_ctrl.sv
// Module: pgc_inst_ctrl
// Per-instance power, clock and repower-reset sequencing.
// Assumes: gate_i and pctl_i are the values that apply from the next edge;
// the instance is powered out of reset and held in reset for RST_CYCLES.
module pgc_inst_ctrl #(
    parameter int unsigned RST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic pctl_i,
    output logic pwr_en_o,
    output logic clk_en_o,
    output logic prst_o
);

    localparam int unsigned      CNT_W    = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

    logic             pwr_q, clk_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             powered_d, repower, clk_d;

    // Power decision, repower detection and reset-window countdown.
    always_comb begin
        powered_d = gate_i | pctl_i;
        repower   = powered_d & ~pwr_q;
        if (!powered_d)         cnt_d = '0;
        else if (repower)       cnt_d = CNT_LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
        else                    cnt_d = cnt_q;
        clk_d = gate_i & (cnt_d == '0);
    end

    // Output registers; reset leaves the instance powered and held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
            clk_q <= 1'b0;
            cnt_q <= CNT_LOAD;
        end else begin
            pwr_q <= powered_d;
            clk_q <= clk_d;
            cnt_q <= cnt_d;
        end
    end

    assign pwr_en_o = pwr_q;
    assign clk_en_o = clk_q;
    assign prst_o   = (cnt_q != '0);

    // R2: a clock is only ever delivered to a powered instance.
    assert_clk_needs_pwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o |-> pwr_en_o);

    // R3: an unpowered instance is quiet.
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_o |-> (!clk_en_o && !prst_o));

    // R7: clock stays off during the peripheral reset.
    assert_no_clk_in_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prst_o |-> !clk_en_o);

    // R7: regained power always brings a reset pulse.
    assert_repower_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> prst_o);

    // R8: a reset pulse starts only together with regained power.
    assert_rst_only_repower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prst_o) |-> $rose(pwr_en_o));

endmodule

// File: rtl/pwr_clk_gate_ctrl.sv
// Module: pwr_clk_gate_ctrl (top)
// Combines mode selection, the power-control register and one sequencer
// per peripheral instance into power, clock and reset enables.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module pwr_clk_gate_ctrl
    import pgc_pkg::*;
#(
    parameter int unsigned       NUM_INST   = 2,
    parameter int unsigned       ADDR_W     = 12,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h938,
    parameter int unsigned       RST_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic [NUM_INST-1:0] run_gate_en_i,
    input  logic [NUM_INST-1:0] slp_gate_en_i,
    input  logic [NUM_INST-1:0] dslp_gate_en_i,
    input  logic                reg_wr_en_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic [NUM_INST-1:0] pwr_en_o,
    output logic [NUM_INST-1:0] clk_en_o,
    output logic [NUM_INST-1:0] periph_rst_o
);

    logic [NUM_INST-1:0] gate_sel;
    logic [NUM_INST-1:0] pctl_q, pctl_d;

    pgc_gate_sel #(.NUM_INST(NUM_INST)) u_gate_sel (
        .mode_i    (mode_i),
        .run_en_i  (run_gate_en_i),
        .slp_en_i  (slp_gate_en_i),
        .dslp_en_i (dslp_gate_en_i),
        .gate_o    (gate_sel)
    );

    pgc_pctl_reg #(
        .NUM_INST   (NUM_INST),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_pctl_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_en_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .pctl_q_o (pctl_q),
        .pctl_d_o (pctl_d)
    );

    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
        pgc_inst_ctrl #(.RST_CYCLES(RST_CYCLES)) u_inst (
            .clk      (clk),
            .rst_n    (rst_n),
            .gate_i   (gate_sel[gi]),
            .pctl_i   (pctl_d[gi]),
            .pwr_en_o (pwr_en_o[gi]),
            .clk_en_o (clk_en_o[gi]),
            .prst_o   (periph_rst_o[gi])
        );

        // R4: gated off with retention requested keeps power on.
        assert_retain_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(gate_sel[gi]) && pctl_q[gi]) |-> (pwr_en_o[gi] && !clk_en_o[gi]));

        // R2: gating enabled in the applied mode always yields power.
        assert_gated_on_pwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(gate_sel[gi]) |-> pwr_en_o[gi]);
    end

endmodule

// File: tb/pwr_clk_gate_ctrl_tb_top.sv
// Scoreboard bench: a driver applies one cycle of stimulus per call and
// queues the outputs the requirements predict; a monitor compares them.
module pwr_clk_gate_ctrl_tb_top;

    localparam logic [11:0] OFF = 12'h938;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [1:0]  run_en = 2'b00, slp_en = 2'b00, dslp_en = 2'b00;
    logic        wr_en = 1'b0;
    logic [11:0] addr = OFF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwr_en, clk_en, prst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pwr_clk_gate_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .run_gate_en_i  (run_en),
        .slp_gate_en_i  (slp_en),
        .dslp_gate_en_i (dslp_en),
        .reg_wr_en_i    (wr_en),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .pwr_en_o       (pwr_en),
        .clk_en_o       (clk_en),
        .periph_rst_o   (prst)
    );

    typedef struct {
        logic [1:0]  pwr;
        logic [1:0]  clk;
        logic [1:0]  rst;
        logic [31:0] rdata;
        int          row [2];
    } exp_t;

    exp_t exp_q[$];

    // Model state derived from the requirements.
    logic [1:0] m_pctl;
    logic [1:0] m_pwr;
    int         m_cnt [2];

    function automatic string row_tag(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus plus the predicted result for the next edge.
    task automatic step(input logic [1:0] m, input logic [1:0] re, input logic [1:0] se,
                        input logic [1:0] de, input logic w, input logic [11:0] a,
                        input logic [31:0] d);
        exp_t       e;
        logic [1:0] sel, pd;
        @(negedge clk);
        rst_n = 1'b1; mode_i = m; run_en = re; slp_en = se; dslp_en = de;
        wr_en = w; addr = a; wdata = d;
        // R1: mode code picks the vector, 11 counts as run.
        case (m)
            2'b01:   sel = se;
            2'b10:   sel = de;
            default: sel = re;
        endcase
        // R5: only a write to the register address changes the low bits.
        pd = (w && a == OFF) ? d[1:0] : m_pctl;
        for (int i = 0; i < 2; i++) begin
            logic pw;
            pw = sel[i] | pd[i];
            // R7: a repower loads a 2-cycle reset window.
            if (!pw)                 m_cnt[i] = 0;
            else if (!m_pwr[i])      m_cnt[i] = 2;
            else if (m_cnt[i] > 0)   m_cnt[i] = m_cnt[i] - 1;
            m_pwr[i]   = pw;
            e.pwr[i]   = pw;
            e.rst[i]   = (m_cnt[i] != 0);
            e.clk[i]   = sel[i] && (m_cnt[i] == 0);
            e.row[i]   = sel[i] ? 2 : (pd[i] ? 4 : 3);
        end
        m_pctl  = pd;
        e.rdata = (a == OFF) ? {30'd0, pd} : 32'd0;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each queued prediction a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                for (int i = 0; i < 2; i++) begin
                    chk(pwr_en[i] == e.pwr[i], {row_tag(e.row[i]), " R1 R6"},
                        $sformatf("pwr_en[%0d]", i), 32'(pwr_en[i]), 32'(e.pwr[i]));
                    chk(clk_en[i] == e.clk[i], {row_tag(e.row[i]), " R1 R6 R7"},
                        $sformatf("clk_en[%0d]", i), 32'(clk_en[i]), 32'(e.clk[i]));
                    chk(prst[i] == e.rst[i], e.rst[i] ? "R7" : "R8",
                        $sformatf("periph_rst[%0d]", i), 32'(prst[i]), 32'(e.rst[i]));
                end
                chk(rdata == e.rdata, "R5", "rdata", rdata, e.rdata);
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        logic [1:0] other;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        // R9: reset state of register and outputs.
        chk(rdata == 32'h3, "R9", "rdata in reset", rdata, 32'h3);
        chk(pwr_en == 2'b11, "R9", "pwr_en in reset", 32'(pwr_en), 32'h3);
        chk(clk_en == 2'b00, "R9", "clk_en in reset", 32'(clk_en), 32'h0);
        chk(prst == 2'b11, "R9", "periph_rst in reset", 32'(prst), 32'h3);
        m_pctl = 2'b11; m_pwr = 2'b11; m_cnt[0] = 2; m_cnt[1] = 2;
        // R9: two more reset cycles after release, then idle in retention.
        repeat (3) step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, OFF, 32'd0);

        // R1..R8: every mode, gate and power-control combination for both instances.
        for (int m = 0; m < 4; m++) begin
            for (int g = 0; g < 4; g++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [1:0] re, se, de;
                    other = ~2'(g);
                    re = (m == 0 || m == 3) ? 2'(g) : other;
                    se = (m == 1) ? 2'(g) : other;
                    de = (m == 2) ? 2'(g) : other;
                    // R5: reserved bits set in every write must be dropped.
                    step(2'(m), re, se, de, 1'b1, OFF, {30'h3FFF_FFFF, 2'(p)});
                    repeat (3) step(2'(m), re, se, de, 1'b0, OFF, 32'd0);
                end
            end
        end

        // R5: a write to a neighbouring address is ignored; read there is zero.
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, OFF, 32'h3);
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, OFF + 12'h4, 32'h0);
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, OFF, 32'h0);
        // R8: power removal by write, then R7 repower by write 0 to 1.
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, OFF, 32'h0);
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, OFF, 32'h1);
        repeat (3) step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, OFF, 32'h0);
        // R7: repower by mode change into a gated-on mode.
        step(2'b01, 2'b00, 2'b11, 2'b00, 1'b0, OFF, 32'h0);
        repeat (3) step(2'b01, 2'b00, 2'b11, 2'b00, 1'b0, OFF, 32'h0);

        repeat (2) @(posedge clk);
        #6;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule